// File: doc/BRIEF.md
# Host Clock Output Generator with Fast/Slow Switching

The block drives one clock pin that feeds a host microcontroller. In fast mode it divides the crystal reference by a ratio chosen with a 3-bit code. While the oscillator is off, it can hand the pin over to the 32 kHz wake-up-timer clock. A host request to stop the oscillator does not cut the clock at once: a tail of 128 or 512 further fast pulses is sent first, so the host has time to reach its own idle state.

The logic clock `clk_i` is the reference-phase clock, which runs at twice the reference frequency. One `clk_i` cycle is therefore half a reference cycle, and this lets the divide-by-1 setting produce a clean registered output. All pulse widths below are given in `clk_i` cycles.

The slow clock arrives asynchronously and passes through a synchronizer. Changes between the fast and slow sources are made only on the falling edges of both clocks. Because of this, no high or low phase on the pin is ever shorter than the fast clock's own phases.

Top module: `mclk_gen`

## Requirements
- R1: The divider code sets the output as (high, low) in `clk_i` cycles: 0→(10,10), 1→(8,8), 2→(6,6), 3→(4,6), 4→(4,4), 5→(2,4), 6→(2,2), 7→(1,1). These are division ratios of 10, 8, 6, 5, 4, 3, 2 and 1 of the reference.
- R2: For the odd ratios 5 and 3, the high phase lasts floor(N/2) reference cycles and the low phase takes the rest of the period.
- R3: While reset is asserted the pin is low. After reset, once `osc_rdy_i` is 1 and `sleep_req_i` is 0, the pin runs at the ratio selected by the code, and code 0 gives 1/10 of the reference.
- R4: While the oscillator is not ready, or a sleep is in force, and the slow clock is not enabled, the pin stays low.
- R5: While `out_dis_i` is 1, the pin is low from the next cycle on, whatever the source.
- R6: A new divider code is taken at the output's next falling edge. The high phase in progress keeps its old width, and the low phase that follows uses the new ratio.
- R7: When `sleep_req_i` rises in fast mode, exactly 128 more fast pulses follow, or 512 if `tail_long_i` was 1 in the cycle the request was taken. Later changes of `tail_long_i` do not alter a tail that has already started.
- R8: After the tail the pin changes to the slow clock if `slow_en_i` is 1, and is otherwise held low.
- R9: A fast-to-slow change stops the fast clock on a fast falling edge and starts the slow clock on a slow falling edge. No phase is shorter than the fast clock's shorter phase.
- R10: A slow-to-fast change waits for `osc_rdy_i`. It then waits for a slow falling edge and begins with a full fast low phase. The first fast rising edge appears no later than one slow period plus one fast period plus 4 `clk_i` cycles after the request.
- R11: If `slow_en_i` is cleared in slow mode, the pin stops low at the next slow falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-phase clock (twice the reference frequency) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_clk_i | input | 1 | 32 kHz wake-up-timer clock, asynchronous |
| osc_rdy_i | input | 1 | Reference oscillator has started and is stable |
| div_sel_i | input | 3 | Fast clock divider code |
| slow_en_i | input | 1 | Allow the slow clock on the pin |
| tail_long_i | input | 1 | 1 selects a 512-pulse tail, 0 a 128-pulse tail |
| out_dis_i | input | 1 | Force the pin low |
| sleep_req_i | input | 1 | Host request to stop the oscillator |
| mclk_o | output | 1 | Host clock pin |

## Verification
Two functions can act in the same cycle: a divider code change, which is applied at the output's falling edge, and the tail counter, which advances on that same falling edge. The bench also lets a tail-select change follow the sleep request by a few cycles. These cases are judged by an exact count of fast pulses, together with the shortest high and low phases seen across the fast-to-slow handover. A separate step changes the code during a high phase and measures that phase and the one after it.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int unsigned CNT_W = 5;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_FAST = 3'd1,
    ST_TAIL = 3'd2,
    ST_PARK = 3'd3,
    ST_SLOW = 3'd4
  } state_e;

  // full period in clk_i ticks (two ticks per reference cycle)
  function automatic logic [CNT_W-1:0] div_period(input logic [2:0] code);
    case (code)
      3'd0:    div_period = 5'd20;
      3'd1:    div_period = 5'd16;
      3'd2:    div_period = 5'd12;
      3'd3:    div_period = 5'd10;
      3'd4:    div_period = 5'd8;
      3'd5:    div_period = 5'd6;
      3'd6:    div_period = 5'd4;
      default: div_period = 5'd2;
    endcase
  endfunction

  // high phase: floor(N/2) reference cycles for odd N >= 3
  function automatic logic [CNT_W-1:0] div_high(input logic [2:0] code);
    case (code)
      3'd0:    div_high = 5'd10;
      3'd1:    div_high = 5'd8;
      3'd2:    div_high = 5'd6;
      3'd3:    div_high = 5'd4;
      3'd4:    div_high = 5'd4;
      3'd5:    div_high = 5'd2;
      3'd6:    div_high = 5'd2;
      default: div_high = 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/mclk_div.sv
module mclk_div
  import mclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       fast_o,
  output logic       fall_o
);
  logic [2:0]       sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hi, per;

  assign hi     = div_high(sel_q);
  assign per    = div_period(sel_q);
  assign fall_o = run_i && (cnt_q == hi - 5'd1);
  assign fast_o = run_i && (cnt_q < hi);

  // idle and falling edge both park the counter at the start of a low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 3'd0;
      cnt_q <= div_high(3'd0);
    end else if (!run_i || fall_o) begin
      sel_q <= sel_i;
      cnt_q <= div_high(sel_i);
    end else if (cnt_q == per - 5'd1) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 5'd1;
    end
  end
endmodule

// File: rtl/mclk_sync.sv
module mclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned LEN = STAGES + 1;
  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LEN-2:0], async_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign fall_o  = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/mclk_ctrl.sv
module mclk_ctrl
  import mclk_pkg::*;
#(
  parameter int unsigned TAIL_SHORT = 128,
  parameter int unsigned TAIL_LONG  = 512
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   osc_rdy_i,
  input  logic   sleep_req_i,
  input  logic   slow_en_i,
  input  logic   tail_long_i,
  input  logic   fast_fall_i,
  input  logic   slow_fall_i,
  output state_e state_o
);
  localparam int unsigned TW = $clog2(TAIL_LONG);

  state_e        st_q, st_n;
  logic [TW-1:0] tcnt_q, lim;
  logic          tail_long_q, want_fast;

  assign want_fast = osc_rdy_i & ~sleep_req_i;
  assign lim       = tail_long_q ? TW'(TAIL_LONG - 1) : TW'(TAIL_SHORT - 1);

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_OFF:  if (want_fast) st_n = ST_FAST;
               else if (slow_en_i && slow_fall_i) st_n = ST_SLOW;
      ST_FAST: if (sleep_req_i) st_n = ST_TAIL;
      ST_TAIL: if (fast_fall_i && tcnt_q == lim) st_n = slow_en_i ? ST_PARK : ST_OFF;
      ST_PARK: if (!slow_en_i) st_n = ST_OFF;
               else if (slow_fall_i) st_n = ST_SLOW;
      ST_SLOW: if (slow_fall_i) begin
                 if (want_fast)       st_n = ST_FAST;
                 else if (!slow_en_i) st_n = ST_OFF;
               end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_OFF;
      tcnt_q      <= '0;
      tail_long_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q == ST_FAST) begin
        tcnt_q <= '0;
        if (sleep_req_i) tail_long_q <= tail_long_i;
      end else if (st_q == ST_TAIL && fast_fall_i) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
  import mclk_pkg::*;
#(
  parameter int unsigned TAIL_SHORT  = 128,
  parameter int unsigned TAIL_LONG   = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slow_clk_i,
  input  logic       osc_rdy_i,
  input  logic [2:0] div_sel_i,
  input  logic       slow_en_i,
  input  logic       tail_long_i,
  input  logic       out_dis_i,
  input  logic       sleep_req_i,
  output logic       mclk_o
);
  state_e st;
  logic   run, fast_clk, fast_fall, slow_lvl, slow_fall, src, mclk_q;

  assign run = (st == ST_FAST) || (st == ST_TAIL);

  mclk_div u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .sel_i (div_sel_i),
    .fast_o(fast_clk),
    .fall_o(fast_fall)
  );

  mclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(slow_clk_i),
    .level_o(slow_lvl),
    .fall_o (slow_fall)
  );

  mclk_ctrl #(.TAIL_SHORT(TAIL_SHORT), .TAIL_LONG(TAIL_LONG)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_rdy_i  (osc_rdy_i),
    .sleep_req_i(sleep_req_i),
    .slow_en_i  (slow_en_i),
    .tail_long_i(tail_long_i),
    .fast_fall_i(fast_fall),
    .slow_fall_i(slow_fall),
    .state_o    (st)
  );

  always_comb begin
    case (st)
      ST_FAST, ST_TAIL: src = fast_clk;
      ST_SLOW:          src = slow_lvl;
      default:          src = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mclk_q <= 1'b0;
    else         mclk_q <= src & ~out_dis_i;
  end

  assign mclk_o = mclk_q;
endmodule

// File: rtl/mclk_gen_chk.sv
module mclk_gen_chk
  import mclk_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   out_dis_i,
  input logic   osc_rdy_i,
  input logic   slow_en_i,
  input state_e st_i,
  input logic   fast_fall_i,
  input logic   mclk_o
);
  assert_dis_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dis_i |=> !mclk_o);

  assert_off_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_OFF) |=> !mclk_o);

  assert_fast_needs_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_FAST && !osc_rdy_i) |=> (st_i != ST_FAST));

  assert_fast_only_to_tail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_FAST) |=> (st_i != ST_SLOW && st_i != ST_PARK));

  assert_tail_ends_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_TAIL && !fast_fall_i) |=> (st_i == ST_TAIL));

  assert_park_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PARK && !slow_en_i) |=> (st_i == ST_OFF));
endmodule

bind mclk_gen mclk_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .out_dis_i  (out_dis_i),
  .osc_rdy_i  (osc_rdy_i),
  .slow_en_i  (slow_en_i),
  .st_i       (st),
  .fast_fall_i(fast_fall),
  .mclk_o     (mclk_o)
);

// File: tb/mclk_gen_tb.sv
module mclk_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slow_clk_i = 1'b0;
  logic       osc_rdy_i = 1'b0;
  logic [2:0] div_sel_i = 3'd0;
  logic       slow_en_i = 1'b0;
  logic       tail_long_i = 1'b0;
  logic       out_dis_i = 1'b0;
  logic       sleep_req_i = 1'b1;
  logic       mclk_o;

  int n_chk = 0;
  int n_err = 0;

  localparam int SLOW_HALF = 37;
  localparam int VEC [8][3] = '{
    '{0, 10, 10}, '{1, 8, 8}, '{2, 6, 6}, '{3, 4, 6},
    '{4, 4, 4},   '{5, 2, 4}, '{6, 2, 2}, '{7, 1, 1}
  };

  mclk_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_clk_i(slow_clk_i), .osc_rdy_i(osc_rdy_i),
    .div_sel_i(div_sel_i), .slow_en_i(slow_en_i), .tail_long_i(tail_long_i),
    .out_dis_i(out_dis_i), .sleep_req_i(sleep_req_i), .mclk_o(mclk_o)
  );

  always #10 clk_i = ~clk_i;
  always #(SLOW_HALF * 20) slow_clk_i = ~slow_clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    bit prev;
    prev = mclk_o;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if (mclk_o && !prev) return;
      prev = mclk_o;
    end
  endtask

  task automatic wait_fall();
    bit prev;
    prev = mclk_o;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if (!mclk_o && prev) return;
      prev = mclk_o;
    end
  endtask

  task automatic len_level(input bit lvl, output int n);
    n = 0;
    while (mclk_o == lvl && n < 5000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  // classifies pulses: high shorter than 20 cycles is fast, otherwise slow
  task automatic observe(input int cycles, output int nf, output int ns,
                         output int min_hi, output int min_lo, output int first_fast);
    bit prev, seen;
    int run_len, rise_t;
    nf = 0; ns = 0; min_hi = 9999; min_lo = 9999; first_fast = -1;
    seen = 1'b0; run_len = 0; rise_t = 0;
    @(negedge clk_i);
    prev = mclk_o;
    for (int t = 1; t <= cycles; t++) begin
      @(negedge clk_i);
      run_len++;
      if (mclk_o != prev) begin
        if (seen) begin
          if (prev && run_len < min_hi) min_hi = run_len;
          if (!prev && run_len < min_lo) min_lo = run_len;
        end
        if (prev && seen) begin
          if (run_len < 20) begin
            nf++;
            if (first_fast < 0) first_fast = rise_t;
          end else ns++;
        end
        if (mclk_o) begin
          rise_t = t;
          seen = 1'b1;
        end
        run_len = 0;
      end
      prev = mclk_o;
    end
  endtask

  initial begin
    #(150000 * 20);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int hi, lo, nf, ns, mh, ml, ff;
    // R3 reset state
    repeat (5) @(negedge clk_i);
    chk(mclk_o == 1'b0, "R3 low in reset", mclk_o, 0);
    rst_ni = 1'b1;
    // R4 no oscillator, no slow clock
    observe(200, nf, ns, mh, ml, ff);
    chk(nf + ns == 0, "R4 held low", nf + ns, 0);

    // R3 start-up at default code 0
    osc_rdy_i = 1'b1; sleep_req_i = 1'b0;
    repeat (40) @(negedge clk_i);
    wait_rise(); len_level(1'b1, hi); len_level(1'b0, lo);
    chk(hi == 10 && lo == 10, "R3 default ratio high", hi, 10);

    // R1 R2 ratio table
    foreach (VEC[k]) begin
      div_sel_i = 3'(VEC[k][0]);
      repeat (60) @(negedge clk_i);
      wait_rise(); len_level(1'b1, hi); len_level(1'b0, lo);
      chk(hi == VEC[k][1], "R1 R2 high width", hi, VEC[k][1]);
      chk(lo == VEC[k][2], "R1 R2 low width", lo, VEC[k][2]);
    end

    // R6 code change during a high phase
    div_sel_i = 3'd0;
    repeat (60) @(negedge clk_i);
    wait_rise();
    repeat (3) @(negedge clk_i);
    div_sel_i = 3'd6;
    len_level(1'b1, hi);
    chk(hi + 3 == 10, "R6 current high keeps old width", hi + 3, 10);
    len_level(1'b0, lo);
    chk(lo == 2, "R6 next low uses new ratio", lo, 2);
    len_level(1'b1, hi);
    chk(hi == 2, "R6 next high uses new ratio", hi, 2);

    // R5 output disable
    out_dis_i = 1'b1;
    @(negedge clk_i);
    observe(100, nf, ns, mh, ml, ff);
    chk(nf + ns == 0, "R5 disabled pin low", nf + ns, 0);
    out_dis_i = 1'b0;

    // R7 R8 short tail, no slow clock
    div_sel_i = 3'd4;
    repeat (60) @(negedge clk_i);
    wait_fall();
    sleep_req_i = 1'b1;
    observe(128 * 8 + 400, nf, ns, mh, ml, ff);
    chk(nf == 128, "R7 short tail count", nf, 128);
    chk(ns == 0, "R8 low after tail without slow clock", ns, 0);

    // R7 R9 long tail, tail select changed after request, then slow clock
    sleep_req_i = 1'b0;
    repeat (80) @(negedge clk_i);
    tail_long_i = 1'b1; slow_en_i = 1'b1;
    wait_fall();
    sleep_req_i = 1'b1;
    repeat (5) @(negedge clk_i);
    tail_long_i = 1'b0;
    observe(512 * 8 + 600, nf, ns, mh, ml, ff);
    chk(nf == 511 || nf == 512, "R7 long tail count", nf, 512);
    chk(ns >= 3, "R8 slow clock after tail", ns, 3);
    chk(mh >= 4, "R9 min high at handover", mh, 4);
    chk(ml >= 4, "R9 min low at handover", ml, 4);

    // R10 wait for ready, then bounded latency
    osc_rdy_i = 1'b0; sleep_req_i = 1'b0;
    observe(400, nf, ns, mh, ml, ff);
    chk(nf == 0, "R10 no fast clock before ready", nf, 0);
    chk(ns >= 2, "R10 slow clock continues", ns, 2);
    osc_rdy_i = 1'b1;
    observe(300, nf, ns, mh, ml, ff);
    chk(ff >= 0 && ff <= 2 * SLOW_HALF + 8 + 4, "R10 latency to first fast edge", ff, 86);
    chk(mh >= 4 && ml >= 4, "R10 no short phase", (mh < ml) ? mh : ml, 4);

    // R11 slow enable removed in slow mode
    wait_fall();
    sleep_req_i = 1'b1;
    observe(128 * 8 + 300, nf, ns, mh, ml, ff);
    chk(nf == 128 || nf == 127, "R7 tail before slow", nf, 128);
    slow_en_i = 1'b0;
    repeat (100) @(negedge clk_i);
    observe(300, nf, ns, mh, ml, ff);
    chk(nf + ns == 0, "R11 low after slow disabled", nf + ns, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule